// File: doc/BRIEF.md
# Bit-Serial Dot-Product PE Array

This block evaluates one low-precision dot product per column of a grid of processing elements. Each PE holds a single weight and receives one bit of its row's activation in every step; all PEs form their partial products in the same cycle, and a column adder tree folds them into one column sum. At the bottom of each column an accumulator doubles its running value and adds the new column sum. Activation bits are applied most significant plane first, so after P steps the accumulator holds the full multi-bit dot product for precision P.

Operands for the next pass can be written while the current one runs. Weights live in two banks: the host writes rows into the bank it names and issues a swap request to make that bank active; a swap is applied only between passes. Activation bit-planes are written into a fill buffer that is copied into a run buffer at the moment a pass is accepted. A start strobe launches a pass with the precision presented at that edge, and one valid pulse marks the finished column results.

Top module: `bitserial_pe_array`

## Requirements
- R1: While and after reset, res_valid is low, every res_data field is zero, and weight bank 0 is the active bank.
- R2: For precision P from 2 to 4, column c reports sum over rows r of A_r times W_rc. A_r is unsigned and built from activation planes 0 to P-1, plane k carrying weight 2^k (act_bits[r] written with act_idx = k). W_rc is the low P bits of the stored weight read as two's complement. Planes at or above P have no effect. Column c occupies res_data[c*ACC_W +: ACC_W] in two's complement, ACC_W = 15 by default.
- R3: With precision 1 a weight whose bit 0 is 0 counts as -1 and one whose bit 0 is 1 counts as +1; the result is the signed count over rows whose plane-0 bit is set.
- R4: A start accepted at clock edge E makes res_valid high for one cycle after edge E+P, and res_data changes only at that edge.
- R5: The precision input is clamped when a pass is accepted: 0 behaves as 1 and any value above 4 behaves as 4.
- R6: A weight write stores w_data[c*4 +: 4] as the weight of row w_row, column c, in the bank given by w_bank (0 or 1); writing the inactive bank during a pass leaves that pass's result unchanged.
- R7: A bank_swap pulse toggles the active bank. When no pass is running it applies at that edge, including to a pass accepted at the same edge. During a pass it is held, the running pass finishes on the old bank, and the toggle applies at the pass's final edge.
- R8: Activation writes during a pass go to the fill buffer only; the running pass uses the planes present when it was accepted, and the next accepted pass uses the new ones.
- R9: A start raised while a pass is running and not in its final step is ignored and produces no extra result; a start in the final step cycle begins the next pass immediately, with no idle cycle.
- R10: The accumulators clear whenever a pass is accepted, so a back-to-back pass reports only its own dot products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| w_we | input | 1 | Weight row write enable |
| w_bank | input | 1 | Weight bank written by this write |
| w_row | input | $clog2(ROWS) | Row written |
| w_data | input | COLS*MAX_PREC | One weight per column, column c at bits c*MAX_PREC upward |
| bank_swap | input | 1 | Request to toggle the active weight bank |
| act_we | input | 1 | Activation plane write enable |
| act_idx | input | $clog2(MAX_PREC) | Bit significance of the plane written |
| act_bits | input | ROWS | One activation bit per row |
| prec | input | $clog2(MAX_PREC+1) | Operand precision in bits |
| start | input | 1 | Launch a pass |
| res_valid | output | 1 | One-cycle pulse marking new column results |
| res_data | output | COLS*ACC_W | Signed accumulated result per column |

## Verification
A wrong step counter or a mis-latched precision shifts the valid pulse by whole cycles or folds in the wrong plane, so the bench records the exact cycle of every expected result and compares both value and timing on the first pulse after the start. A bank toggled at the wrong moment, a run buffer overwritten mid-pass or an accumulator that fails to clear shows as a wrong column value on the very pass concerned, because every scenario places the disturbing write, swap or start inside a live pass and predicts the result from the operands captured at acceptance. A start that is wrongly honoured shows as a pulse nobody expected.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  function automatic int clamp_prec(input int p, input int maxp);
    int r;
    r = p;
    if (r < 1) r = 1;
    if (r > maxp) r = maxp;
    return r;
  endfunction

endpackage

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
  import bsa_pkg::*;
#(
  parameter  int MAX_PREC = 4,
  localparam int PREC_W   = $clog2(MAX_PREC + 1),
  localparam int PLANE_W  = $clog2(MAX_PREC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               swap_i,
  input  logic [PREC_W-1:0]  prec_i,
  output logic               busy_o,
  output logic               last_o,
  output logic               accept_o,
  output logic               valid_o,
  output logic               bank_o,
  output logic [PLANE_W-1:0] plane_o,
  output logic [PREC_W-1:0]  prec_o
);

  run_state_e         state_q, state_d;
  logic [PLANE_W-1:0] step_q, step_d;
  logic [PREC_W-1:0]  prec_q, prec_d;
  logic               pend_q, pend_d;
  logic               bank_q, bank_d;
  logic               valid_q, valid_d;
  logic               busy, last, boundary, accept, swap_now;

  always_comb begin
    busy     = (state_q == ST_RUN);
    last     = busy && (int'(step_q) == int'(prec_q) - 1);
    boundary = !busy || last;
    accept   = start_i && boundary;
    swap_now = (pend_q || swap_i) && boundary;

    state_d = state_q;
    step_d  = step_q;
    prec_d  = prec_q;
    if (accept) begin
      state_d = ST_RUN;
      step_d  = '0;
      prec_d  = PREC_W'(clamp_prec(int'(prec_i), MAX_PREC));
    end else if (last) begin
      state_d = ST_IDLE;
    end else if (busy) begin
      step_d = step_q + 1'b1;
    end

    valid_d = last;
    bank_d  = swap_now ? ~bank_q : bank_q;
    pend_d  = swap_now ? 1'b0 : (pend_q || swap_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      prec_q  <= '0;
      pend_q  <= 1'b0;
      bank_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      bank_q  <= bank_d;
      pend_q  <= pend_d;
      if (accept || busy) step_q <= step_d;
      if (accept)         prec_q <= prec_d;
    end
  end

  assign busy_o   = busy;
  assign last_o   = last;
  assign accept_o = accept;
  assign valid_o  = valid_q;
  assign bank_o   = bank_q;
  assign prec_o   = prec_q;
  assign plane_o  = PLANE_W'(int'(prec_q) - 1 - int'(step_q));

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(step_q) < int'(prec_q))); // R4

  AST_PREC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (prec_q >= 1 && int'(prec_q) <= MAX_PREC)); // R5

  AST_BANK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(bank_q)); // R7

  AST_VALID_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && prec_q != 1) |=> !valid_q); // R4

endmodule

// File: rtl/bsa_wstore.sv
module bsa_wstore #(
  parameter  int ROWS     = 32,
  parameter  int COLS     = 16,
  parameter  int MAX_PREC = 4,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int WORD_W   = COLS * MAX_PREC
) (
  input  logic                   clk,
  input  logic                   we_i,
  input  logic                   bank_i,
  input  logic [ROW_W-1:0]       row_i,
  input  logic [WORD_W-1:0]      data_i,
  input  logic                   sel_i,
  output logic [ROWS*WORD_W-1:0] w_o
);

  logic [WORD_W-1:0] mem_q [2][ROWS];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[bank_i][row_i] <= data_i;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign w_o[r*WORD_W +: WORD_W] = mem_q[sel_i][r];
  end

endmodule

// File: rtl/bsa_astore.sv
module bsa_astore #(
  parameter  int ROWS     = 32,
  parameter  int MAX_PREC = 4,
  localparam int PLANE_W  = $clog2(MAX_PREC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [PLANE_W-1:0] idx_i,
  input  logic [ROWS-1:0]    bits_i,
  input  logic               load_i,
  input  logic               busy_i,
  input  logic [PLANE_W-1:0] sel_i,
  output logic [ROWS-1:0]    plane_o
);

  logic [ROWS-1:0]          fill_q [MAX_PREC];
  logic [ROWS-1:0]          run_q  [MAX_PREC];
  logic [MAX_PREC*ROWS-1:0] run_flat;

  always_ff @(posedge clk) begin
    if (we_i)   fill_q[idx_i] <= bits_i;
    if (load_i) run_q <= fill_q;
  end

  for (genvar k = 0; k < MAX_PREC; k++) begin : g_flat
    assign run_flat[k*ROWS +: ROWS] = run_q[k];
  end

  assign plane_o = run_q[sel_i];

  AST_RUN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !load_i) |=> $stable(run_flat)); // R8

endmodule

// File: rtl/bsa_pe.sv
module bsa_pe #(
  parameter  int MAX_PREC = 4,
  localparam int PREC_W   = $clog2(MAX_PREC + 1),
  localparam int IDX_W    = $clog2(MAX_PREC),
  localparam int PV_W     = MAX_PREC + 2
) (
  input  logic [MAX_PREC-1:0] w_i,
  input  logic                a_i,
  input  logic [PREC_W-1:0]   prec_i,
  output logic [PV_W-1:0]     p_o
);

  int                  pr;
  logic [MAX_PREC-1:0] mask;
  logic [IDX_W-1:0]    sidx;
  logic [PV_W-1:0]     mag, val;

  always_comb begin
    pr   = int'(prec_i);
    mask = MAX_PREC'((1 << pr) - 1);
    sidx = IDX_W'(pr - 1);
    mag  = PV_W'(w_i & mask);
    if (pr <= 1)         val = w_i[0] ? PV_W'(1) : '1;
    else if (w_i[sidx])  val = mag - PV_W'(1 << pr);
    else                 val = mag;
    p_o = a_i ? val : '0;
  end

endmodule

// File: rtl/bsa_column.sv
module bsa_column #(
  parameter  int ROWS     = 32,
  parameter  int MAX_PREC = 4,
  localparam int PREC_W   = $clog2(MAX_PREC + 1),
  localparam int PV_W     = MAX_PREC + 2,
  localparam int CS_W     = PV_W + $clog2(ROWS),
  localparam int ACC_W    = CS_W + MAX_PREC
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ROWS*MAX_PREC-1:0] w_i,
  input  logic [ROWS-1:0]          a_i,
  input  logic [PREC_W-1:0]        prec_i,
  input  logic                     clear_i,
  input  logic                     step_i,
  input  logic                     fin_i,
  output logic [ACC_W-1:0]         res_o
);

  logic [PV_W-1:0]  part [ROWS];
  logic [CS_W-1:0]  colsum;
  logic [ACC_W-1:0] acc_q, acc_nxt, res_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_pe
    bsa_pe #(.MAX_PREC(MAX_PREC)) u_pe (
      .w_i    (w_i[r*MAX_PREC +: MAX_PREC]),
      .a_i    (a_i[r]),
      .prec_i (prec_i),
      .p_o    (part[r])
    );
  end

  always_comb begin
    colsum = '0;
    for (int r = 0; r < ROWS; r++) begin
      colsum = colsum + {{(CS_W-PV_W){part[r][PV_W-1]}}, part[r]};
    end
    acc_nxt = {acc_q[ACC_W-2:0], 1'b0} + {{(ACC_W-CS_W){colsum[CS_W-1]}}, colsum};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (clear_i)     acc_q <= '0;
      else if (step_i) acc_q <= acc_nxt;
      if (fin_i)       res_q <= acc_nxt;
    end
  end

  assign res_o = res_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (acc_q[ACC_W-1] == acc_q[ACC_W-2])); // R2

endmodule

// File: rtl/bitserial_pe_array.sv
module bitserial_pe_array #(
  parameter  int ROWS     = 32,
  parameter  int COLS     = 16,
  parameter  int MAX_PREC = 4,
  localparam int ROW_W    = $clog2(ROWS),
  localparam int PLANE_W  = $clog2(MAX_PREC),
  localparam int PREC_W   = $clog2(MAX_PREC + 1),
  localparam int WORD_W   = COLS * MAX_PREC,
  localparam int ACC_W    = MAX_PREC + 2 + $clog2(ROWS) + MAX_PREC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  w_we,
  input  logic                  w_bank,
  input  logic [ROW_W-1:0]      w_row,
  input  logic [WORD_W-1:0]     w_data,
  input  logic                  bank_swap,
  input  logic                  act_we,
  input  logic [PLANE_W-1:0]    act_idx,
  input  logic [ROWS-1:0]       act_bits,
  input  logic [PREC_W-1:0]     prec,
  input  logic                  start,
  output logic                  res_valid,
  output logic [COLS*ACC_W-1:0] res_data
);

  logic [1:0]               rst_sync_q;
  logic                     rst_ni;
  logic                     busy, last, accept, bank;
  logic [PLANE_W-1:0]       plane_sel;
  logic [PREC_W-1:0]        prec_q;
  logic [ROWS*WORD_W-1:0]   w_flat;
  logic [ROWS-1:0]          plane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  bsa_ctrl #(.MAX_PREC(MAX_PREC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_ni),
    .start_i  (start),
    .swap_i   (bank_swap),
    .prec_i   (prec),
    .busy_o   (busy),
    .last_o   (last),
    .accept_o (accept),
    .valid_o  (res_valid),
    .bank_o   (bank),
    .plane_o  (plane_sel),
    .prec_o   (prec_q)
  );

  bsa_wstore #(.ROWS(ROWS), .COLS(COLS), .MAX_PREC(MAX_PREC)) u_wstore (
    .clk    (clk),
    .we_i   (w_we),
    .bank_i (w_bank),
    .row_i  (w_row),
    .data_i (w_data),
    .sel_i  (bank),
    .w_o    (w_flat)
  );

  bsa_astore #(.ROWS(ROWS), .MAX_PREC(MAX_PREC)) u_astore (
    .clk     (clk),
    .rst_n   (rst_ni),
    .we_i    (act_we),
    .idx_i   (act_idx),
    .bits_i  (act_bits),
    .load_i  (accept),
    .busy_i  (busy),
    .sel_i   (plane_sel),
    .plane_o (plane)
  );

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS*MAX_PREC-1:0] col_w;
    for (genvar r = 0; r < ROWS; r++) begin : g_tap
      assign col_w[r*MAX_PREC +: MAX_PREC] = w_flat[r*WORD_W + c*MAX_PREC +: MAX_PREC];
    end
    bsa_column #(.ROWS(ROWS), .MAX_PREC(MAX_PREC)) u_col (
      .clk     (clk),
      .rst_n   (rst_ni),
      .w_i     (col_w),
      .a_i     (plane),
      .prec_i  (prec_q),
      .clear_i (accept),
      .step_i  (busy),
      .fin_i   (last),
      .res_o   (res_data[c*ACC_W +: ACC_W])
    );
  end

endmodule

// File: tb/bitserial_pe_array_tb.sv
module bitserial_pe_array_tb;

  localparam int ROWS  = 32;
  localparam int COLS  = 16;
  localparam int MAXP  = 4;
  localparam int ACC_W = MAXP + 2 + $clog2(ROWS) + MAXP;
  localparam int RES_W = COLS * ACC_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             w_we, w_bank, bank_swap, act_we, start;
  logic [4:0]       w_row;
  logic [COLS*MAXP-1:0] w_data;
  logic [1:0]       act_idx;
  logic [ROWS-1:0]  act_bits;
  logic [2:0]       prec;
  logic             res_valid;
  logic [RES_W-1:0] res_data;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic mon_on = 1'b0;

  logic [RES_W-1:0] q_data [$];
  int               q_when [$];
  string            q_tag  [$];

  logic [MAXP-1:0] mw [2][ROWS][COLS];
  logic [ROWS-1:0] mfill [MAXP];
  int              mbank = 0;

  bitserial_pe_array u_dut (
    .clk(clk), .rst_n(rst_n), .w_we(w_we), .w_bank(w_bank), .w_row(w_row),
    .w_data(w_data), .bank_swap(bank_swap), .act_we(act_we), .act_idx(act_idx),
    .act_bits(act_bits), .prec(prec), .start(start),
    .res_valid(res_valid), .res_data(res_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int wval(input logic [MAXP-1:0] w, input int p);
    int m;
    if (p == 1) return w[0] ? 1 : -1;
    m = int'(w) & ((1 << p) - 1);
    if (w[p-1]) m = m - (1 << p);
    return m;
  endfunction

  function automatic logic [RES_W-1:0] model(input int p);
    logic [RES_W-1:0] v;
    int acc, a;
    v = '0;
    for (int c = 0; c < COLS; c++) begin
      acc = 0;
      for (int r = 0; r < ROWS; r++) begin
        a = 0;
        for (int k = 0; k < p; k++) if (mfill[k][r]) a = a + (1 << k);
        acc = acc + a * wval(mw[mbank][r][c], p);
      end
      v[c*ACC_W +: ACC_W] = ACC_W'(acc);
    end
    return v;
  endfunction

  task automatic write_row(input int b, input int r);
    w_we = 1'b1; w_bank = b[0]; w_row = 5'(r);
    for (int c = 0; c < COLS; c++) w_data[c*MAXP +: MAXP] = mw[b][r][c];
    @(negedge clk);
    w_we = 1'b0;
  endtask

  task automatic load_bank(input int b, input int s);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) mw[b][r][c] = 4'(r*7 + c*13 + s*5 + r*c + b*3);
      write_row(b, r);
    end
  endtask

  task automatic set_plane(input int k, input int s);
    logic [ROWS-1:0] bits;
    bits = ROWS'(32'h9E3779B9 * (k + 1) + s * 32'h01234567 + (s << k));
    mfill[k] = bits;
    act_we = 1'b1; act_idx = 2'(k); act_bits = bits;
    @(negedge clk);
    act_we = 1'b0;
  endtask

  task automatic set_all_planes(input int s);
    for (int k = 0; k < MAXP; k++) set_plane(k, s);
  endtask

  task automatic start_pass(input int p_in, input string tag);
    int pe;
    pe = (p_in < 1) ? 1 : ((p_in > MAXP) ? MAXP : p_in);
    q_data.push_back(model(pe));
    q_when.push_back(cyc + 1 + pe);
    q_tag.push_back(tag);
    prec = 3'(p_in); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(negedge clk) begin
    if (mon_on && res_valid) begin
      if (q_data.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9 unexpected res_valid at cycle %0d: actual 1 expected 0", cyc);
      end else begin
        logic [RES_W-1:0] e;
        int w;
        string t;
        e = q_data.pop_front(); w = q_when.pop_front(); t = q_tag.pop_front();
        n_cmp++;
        if (res_data !== e) begin
          n_bad++;
          $display("FAIL %s data: actual %h expected %h", t, res_data, e);
        end
        n_cmp++;
        if (cyc != w) begin
          n_bad++;
          $display("FAIL R4 (%s) valid cycle: actual %0d expected %0d", t, cyc, w);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; w_we = 1'b0; w_bank = 1'b0; w_row = '0; w_data = '0;
    bank_swap = 1'b0; act_we = 1'b0; act_idx = '0; act_bits = '0;
    prec = 3'd4; start = 1'b0;
    repeat (4) @(negedge clk);
    n_cmp++;
    if (res_valid !== 1'b0 || res_data !== '0) begin
      n_bad++;
      $display("FAIL R1 in reset: actual valid=%b data=%h expected 0/0", res_valid, res_data);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_cmp++;
    if (res_valid !== 1'b0 || res_data !== '0) begin
      n_bad++;
      $display("FAIL R1 after reset: actual valid=%b data=%h expected 0/0", res_valid, res_data);
    end
    mon_on = 1'b1;

    load_bank(0, 1);
    load_bank(1, 2);
    set_all_planes(1);
    start_pass(4, "R1 R2 bank0 prec4");
    wait_idle();

    set_all_planes(2);
    start_pass(3, "R2 prec3");
    wait_idle();
    start_pass(2, "R2 prec2");
    wait_idle();

    set_all_planes(3);
    start_pass(1, "R3 prec1");
    wait_idle();

    start_pass(0, "R5 prec0 as 1");
    wait_idle();
    start_pass(7, "R5 prec7 as 4");
    wait_idle();

    start_pass(4, "R8 current planes");
    set_all_planes(4);
    wait_idle();
    start_pass(4, "R8 next planes");
    wait_idle();

    start_pass(4, "R9 first pass");
    prec = 3'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    set_all_planes(5);
    wait_idle();

    start_pass(4, "R9 lead pass");
    repeat (3) @(negedge clk);
    start_pass(2, "R9 R10 back-to-back");
    wait_idle();

    start_pass(4, "R6 R7 old bank");
    bank_swap = 1'b1;
    @(negedge clk);
    bank_swap = 1'b0;
    mw[1][5][3] = 4'h7;
    write_row(1, 5);
    wait_idle();
    mbank = 1;
    start_pass(4, "R6 R7 swapped bank");
    wait_idle();

    bank_swap = 1'b1;
    @(negedge clk);
    bank_swap = 1'b0;
    mbank = 0;
    start_pass(3, "R7 idle swap");
    wait_idle();

    mbank = 1;
    bank_swap = 1'b1;
    start_pass(4, "R7 swap with start");
    bank_swap = 1'b0;
    wait_idle();

    n_cmp++;
    if (q_data.size() != 0) begin
      n_bad++;
      $display("FAIL R4 missing results: actual %0d pending expected 0", q_data.size());
    end
    summary();
    $finish;
  end

endmodule